// File: doc/BRIEF.md
# Four-Bank DRAM Command Timing Monitor

This block is a passive observer that sits beside a four-bank DRAM command path and watches one decoded command per clock: activate, read, write, precharge or refresh, each with a two-bit bank number and an auto-precharge flag. It keeps a small set of saturating cycle counters per bank and a few shared counters. For every command it checks the minimum-spacing rules, plus three state rules: an activate to an open bank, a column access to an idle bank, and a refresh while any bank is open. It also checks a ceiling on how long a bank may stay open.

Each rule minimum is a parameter in clock cycles. The defaults are the fastest grade's times divided by the clock period and rounded up. The write activate delay is derived from the read activate delay: two cycles less, but never below two. When a violation is found, the monitor raises a single-cycle flag and a code. The code carries the rule number and the bank concerned. The monitor never stalls, and it goes on checking every later command.

Top module: `dram_timing_monitor`

## Requirements
- R1: After reset, all banks are idle, every counter counts as long expired, `viol_o` is 0 and `viol_code_o` is 0. Command codes are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge and 5 refresh; codes 6 and 7 act as no-op.
- R2: A command sampled at a clock edge is judged in the next cycle. `viol_o` is high for that one cycle, with `viol_code_o[5:2]` set to the rule number and `viol_code_o[1:1]`…`[0]` (bits 1:0) set to the bank. `viol_code_o` is 0 whenever `viol_o` is low. When several rules break together, the lowest rule number is reported.
- R3: An activate issued k cycles after the last activate to the same bank breaks rule 1 when k < RC. An activate issued k cycles after the last activate to any bank breaks rule 2 when k < RRD.
- R4: An activate issued less than RP cycles after a precharge to its bank breaks rule 3. A precharge here is an explicit precharge, or a read with auto-precharge. An activate or a refresh issued less than RFC cycles after a refresh breaks rule 4, with bank field 0 for a refresh.
- R5: An activate issued less than DAL cycles after a write with auto-precharge to the same bank breaks rule 5.
- R6: An activate to an open bank breaks rule 6. A read or write to an idle bank breaks rule 9.
- R7: A read issued less than RCDRD cycles after the activate to its bank breaks rule 7. A write issued less than max(RCDRD-2, 2) cycles after that activate breaks rule 8.
- R8: A precharge covers one bank, or all banks when the flag is set. It breaks rule 10 when a covered open bank was activated less than RAS cycles earlier. It breaks rule 11 when a covered open bank was written less than WREC cycles earlier. The reported bank is the lowest offending bank.
- R9: A read issued less than WTR cycles after a write to any bank breaks rule 12.
- R10: A refresh while any bank is open breaks rule 13. The reported bank is the lowest open bank.
- R11: A bank still open RAS_MAX+1 cycles after its activate breaks rule 14 once. The reported bank is the lowest such bank, even when no command is present.
- R12: An activate opens its bank, and a precharge closes the banks it covers. A read or write with auto-precharge closes its bank. These state changes take effect even when the command itself breaks a rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command code (see R1) |
| cmd_bank | input | 2 | Target bank |
| cmd_ap | input | 1 | Auto-precharge on read/write, all-bank on precharge |
| viol_o | output | 1 | One-cycle violation flag |
| viol_code_o | output | 6 | Rule number in bits 5:2, bank in bits 1:0 |

## Verification
The embedded properties assume one command per cycle on the op/bank/flag inputs. They also assume the counter width holds RAS_MAX+1 below saturation. They need nothing else from the stimulus, because every command, legal or not, must be judged.

The stimulus mixes a directed sequence with random traffic. The directed sequence places commands exactly one cycle inside and on each boundary, and it holds a bank open past the open-time ceiling. The random traffic draws all eight op codes, any bank and the flag from a fixed seed, with random idle gaps, so that it hits both legal and illegal spacings. A cycle-indexed reference model in the bench supplies the expected code for each random command.

// File: rtl/dram_timing_monitor.sv
module dram_timing_monitor #(
  parameter int RC      = 15,
  parameter int RFC     = 17,
  parameter int RAS     = 10,
  parameter int RCDRD   = 5,
  parameter int RP      = 5,
  parameter int RRD     = 4,
  parameter int DAL     = 10,
  parameter int WREC    = 5,
  parameter int WTR     = 2,
  parameter int RAS_MAX = 34965,
  parameter int CW      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmd_op,
  input  logic [1:0] cmd_bank,
  input  logic       cmd_ap,
  output logic       viol_o,
  output logic [5:0] viol_code_o
);
  localparam int RCDWR = (RCDRD - 2 < 2) ? 2 : RCDRD - 2;
  localparam logic [CW-1:0] SAT     = '1;
  localparam logic [CW-1:0] L_RC    = CW'(RC);
  localparam logic [CW-1:0] L_RFC   = CW'(RFC);
  localparam logic [CW-1:0] L_RAS   = CW'(RAS);
  localparam logic [CW-1:0] L_RCDRD = CW'(RCDRD);
  localparam logic [CW-1:0] L_RCDWR = CW'(RCDWR);
  localparam logic [CW-1:0] L_RP    = CW'(RP);
  localparam logic [CW-1:0] L_RRD   = CW'(RRD);
  localparam logic [CW-1:0] L_DAL   = CW'(DAL);
  localparam logic [CW-1:0] L_WREC  = CW'(WREC);
  localparam logic [CW-1:0] L_WTR   = CW'(WTR);
  localparam logic [CW-1:0] L_OPEN  = CW'(RAS_MAX + 1);

  logic [CW-1:0] act_c [4];
  logic [CW-1:0] pre_c [4];
  logic [CW-1:0] wr_c  [4];
  logic [CW-1:0] dal_c [4];
  logic [CW-1:0] any_act_c, ref_c, any_wr_c;
  logic [3:0]    open_q;

  wire is_act = cmd_op == 3'd1;
  wire is_rd  = cmd_op == 3'd2;
  wire is_wr  = cmd_op == 3'd3;
  wire is_pre = cmd_op == 3'd4;
  wire is_ref = cmd_op == 3'd5;
  wire [1:0] b = cmd_bank;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
    return (c == SAT) ? c : c + 1'b1;
  endfunction

  function automatic logic [1:0] lowest(input logic [3:0] m);
    logic [1:0] r;
    r = 2'd0;
    for (int i = 3; i >= 0; i--) if (m[i]) r = 2'(i);
    return r;
  endfunction

  logic [3:0] tgt, ras_bad, wrec_bad, too_long;
  always_comb begin
    for (int i = 0; i < 4; i++) begin
      tgt[i]      = is_pre && (cmd_ap || b == 2'(i));
      ras_bad[i]  = tgt[i] && open_q[i] && act_c[i] < L_RAS;
      wrec_bad[i] = tgt[i] && open_q[i] && wr_c[i] < L_WREC;
      too_long[i] = open_q[i] && act_c[i] == L_OPEN;
    end
  end

  logic [14:1] flag;
  assign flag[1]  = is_act && act_c[b] < L_RC;
  assign flag[2]  = is_act && any_act_c < L_RRD;
  assign flag[3]  = is_act && pre_c[b] < L_RP;
  assign flag[4]  = (is_act || is_ref) && ref_c < L_RFC;
  assign flag[5]  = is_act && dal_c[b] < L_DAL;
  assign flag[6]  = is_act && open_q[b];
  assign flag[7]  = is_rd && act_c[b] < L_RCDRD;
  assign flag[8]  = is_wr && act_c[b] < L_RCDWR;
  assign flag[9]  = (is_rd || is_wr) && !open_q[b];
  assign flag[10] = |ras_bad;
  assign flag[11] = |wrec_bad;
  assign flag[12] = is_rd && any_wr_c < L_WTR;
  assign flag[13] = is_ref && |open_q;
  assign flag[14] = |too_long;

  logic [3:0] rule;
  logic [1:0] rbank;
  always_comb begin
    rule = 4'd0;
    for (int i = 14; i >= 1; i--) if (flag[i]) rule = 4'(i);
    case (rule)
      4'd4:    rbank = is_ref ? 2'd0 : b;
      4'd10:   rbank = lowest(ras_bad);
      4'd11:   rbank = lowest(wrec_bad);
      4'd13:   rbank = lowest(open_q);
      4'd14:   rbank = lowest(too_long);
      default: rbank = b;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_o      <= 1'b0;
      viol_code_o <= '0;
      any_act_c   <= SAT;
      ref_c       <= SAT;
      any_wr_c    <= SAT;
      open_q      <= '0;
      for (int i = 0; i < 4; i++) begin
        act_c[i] <= SAT;
        pre_c[i] <= SAT;
        wr_c[i]  <= SAT;
        dal_c[i] <= SAT;
      end
    end else begin
      viol_o      <= rule != 4'd0;
      viol_code_o <= (rule != 4'd0) ? {rule, rbank} : 6'd0;
      any_act_c   <= is_act ? CW'(1) : bump(any_act_c);
      ref_c       <= is_ref ? CW'(1) : bump(ref_c);
      any_wr_c    <= is_wr  ? CW'(1) : bump(any_wr_c);
      for (int i = 0; i < 4; i++) begin
        act_c[i] <= (is_act && b == 2'(i)) ? CW'(1) : bump(act_c[i]);
        pre_c[i] <= (tgt[i] || (is_rd && cmd_ap && b == 2'(i))) ? CW'(1) : bump(pre_c[i]);
        wr_c[i]  <= (is_wr && b == 2'(i)) ? CW'(1) : bump(wr_c[i]);
        dal_c[i] <= (is_wr && cmd_ap && b == 2'(i)) ? CW'(1) : bump(dal_c[i]);
        if (is_act && b == 2'(i))
          open_q[i] <= 1'b1;
        else if (tgt[i] || ((is_rd || is_wr) && cmd_ap && b == 2'(i)))
          open_q[i] <= 1'b0;
      end
    end
  end

  AST_QUIET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_o |-> viol_code_o == 6'd0); // R2
  AST_RULE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> (viol_code_o[5:2] != 4'd0 && viol_code_o[5:2] <= 4'd14)); // R2
  AST_SAME_BANK_RC: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && act_c[b] < L_RC) |=> (viol_o && viol_code_o[5:2] == 4'd1)); // R3
  AST_ACT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && open_q[b]) |=> (viol_o && viol_code_o[5:2] <= 4'd6)); // R6
  AST_IDLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_rd || is_wr) && !open_q[b]) |=> viol_o); // R6
  AST_REF_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && open_q != 4'd0) |=> viol_o); // R10
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |=> open_q[$past(b)]); // R12
endmodule

// File: tb/tb_dram_timing_monitor.sv
`timescale 1ns/1ps
module tb_dram_timing_monitor;
  localparam int RC = 15, RFC = 17, RAS = 10, RCDRD = 5, RP = 5, RRD = 4;
  localparam int DAL = 10, WREC = 5, WTR = 2, RAS_MAX = 34965;
  localparam int RCDWR = (RCDRD - 2 < 2) ? 2 : RCDRD - 2;
  localparam int FAR = -1000000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_bank = '0;
  logic cmd_ap = 1'b0;
  logic viol_o;
  logic [5:0] viol_code_o;

  always #2.5 clk = ~clk;

  dram_timing_monitor dut (.clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
                           .cmd_ap(cmd_ap), .viol_o(viol_o), .viol_code_o(viol_code_o));

  int checks = 0, errors = 0, cyc = 0;
  int la[4], lp[4], lw[4], ld[4], lany, lref, lanyw;
  bit opn[4];
  bit pend = 0;
  int pend_code;
  string pend_tag;

  function automatic string rtag(int code);
    case (code / 4)
      0: return "R2";
      1, 2: return "R3";
      3, 4: return "R4";
      5: return "R5";
      6, 9: return "R6";
      7, 8: return "R7";
      10, 11: return "R8";
      12: return "R9";
      13: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic int expect_code(int op, int b, int ap);
    int rule = 0, bk = 0;
    bit act = op == 1, rd = op == 2, wr = op == 3, pre = op == 4, rf = op == 5;
    if (rule == 0 && act && cyc - la[b] < RC) begin rule = 1; bk = b; end
    if (rule == 0 && act && cyc - lany < RRD) begin rule = 2; bk = b; end
    if (rule == 0 && act && cyc - lp[b] < RP) begin rule = 3; bk = b; end
    if (rule == 0 && (act || rf) && cyc - lref < RFC) begin rule = 4; bk = act ? b : 0; end
    if (rule == 0 && act && cyc - ld[b] < DAL) begin rule = 5; bk = b; end
    if (rule == 0 && act && opn[b]) begin rule = 6; bk = b; end
    if (rule == 0 && rd && cyc - la[b] < RCDRD) begin rule = 7; bk = b; end
    if (rule == 0 && wr && cyc - la[b] < RCDWR) begin rule = 8; bk = b; end
    if (rule == 0 && (rd || wr) && !opn[b]) begin rule = 9; bk = b; end
    for (int i = 3; i >= 0; i--)
      if (pre && (ap != 0 || b == i) && opn[i] && cyc - la[i] < RAS && (rule == 0 || rule == 10)) begin rule = 10; bk = i; end
    for (int i = 3; i >= 0; i--)
      if (pre && (ap != 0 || b == i) && opn[i] && cyc - lw[i] < WREC && (rule == 0 || rule == 11)) begin rule = 11; bk = i; end
    if (rule == 0 && rd && cyc - lanyw < WTR) begin rule = 12; bk = b; end
    for (int i = 3; i >= 0; i--)
      if (rf && opn[i] && (rule == 0 || rule == 13)) begin rule = 13; bk = i; end
    for (int i = 3; i >= 0; i--)
      if (opn[i] && cyc - la[i] == RAS_MAX + 1 && (rule == 0 || rule == 14)) begin rule = 14; bk = i; end
    return rule * 4 + bk;
  endfunction

  function automatic void model_update(int op, int b, int ap);
    case (op)
      1: begin la[b] = cyc; lany = cyc; opn[b] = 1; end
      2: if (ap != 0) begin lp[b] = cyc; opn[b] = 0; end
      3: begin lw[b] = cyc; lanyw = cyc; if (ap != 0) begin ld[b] = cyc; opn[b] = 0; end end
      4: for (int i = 0; i < 4; i++) if (ap != 0 || b == i) begin lp[i] = cyc; opn[i] = 0; end
      5: lref = cyc;
      default: ;
    endcase
  endfunction

  task automatic check_pending();
    if (pend) begin
      checks++;
      if (viol_o !== (pend_code != 0) || viol_code_o !== 6'(pend_code)) begin
        errors++;
        $display("FAIL %s: cycle %0d viol=%0b code=%0d, expected viol=%0b code=%0d",
                 pend_tag, cyc, viol_o, viol_code_o, pend_code != 0, pend_code);
      end
    end
  endtask

  task automatic tick(int op, int b, int ap, int hand, string tg);
    int e;
    @(negedge clk);
    check_pending();
    e = expect_code(op, b, ap);
    pend = 1;
    pend_code = (hand >= 0) ? hand : e;
    pend_tag  = (hand >= 0) ? tg : rtag(e);
    cmd_op = 3'(op); cmd_bank = 2'(b); cmd_ap = ap[0];
    model_update(op, b, ap);
    cyc++;
  endtask

  task automatic nops(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, -1, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin la[i] = FAR; lp[i] = FAR; lw[i] = FAR; ld[i] = FAR; opn[i] = 0; end
    lany = FAR; lref = FAR; lanyw = FAR;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (viol_o !== 1'b0 || viol_code_o !== 6'd0) begin
      errors++;
      $display("FAIL R1: reset viol=%0b code=%0d, expected viol=0 code=0", viol_o, viol_code_o);
    end
    // directed corner cases
    tick(1, 0, 0, 0, "R1 legal first activate");
    nops(3);
    tick(2, 0, 0, 28, "R7 read one cycle early");
    tick(2, 0, 0, 0,  "R7 read on boundary");
    tick(3, 0, 0, 0,  "R7 write after write delay");
    tick(2, 0, 0, 48, "R9 read right after write");
    tick(2, 0, 0, 0,  "R9 read on boundary");
    tick(4, 0, 0, 40, "R8 early precharge, R2 lowest rule wins");
    tick(1, 0, 0, 4,  "R3 same-bank activate spacing");
    tick(2, 2, 0, 38, "R6 read to idle bank");
    nops(20);
    tick(1, 0, 0, 24, "R6 activate to open bank");
    tick(1, 1, 0, 9,  "R3 bank-to-bank spacing");
    nops(3);
    tick(1, 2, 0, 0,  "R3 bank-to-bank boundary");
    tick(5, 0, 0, 52, "R10 refresh with open banks");
    tick(4, 0, 1, 40, "R8 all-bank precharge lowest bank");
    tick(5, 0, 0, 16, "R4 refresh spacing");
    nops(16);
    tick(1, 3, 0, 0,  "R4 activate at refresh boundary");
    nops(7);
    tick(3, 3, 1, 0,  "R12 write with auto-precharge");
    tick(2, 3, 0, 39, "R12 bank closed by auto-precharge");
    nops(5);
    tick(1, 3, 0, 23, "R5 activate inside auto-precharge recovery");
    nops(RAS_MAX);
    tick(0, 0, 0, 59, "R11 bank open too long");
    tick(0, 0, 0, 0,  "R11 reported once");
    tick(4, 3, 0, 0,  "R8 late precharge is legal");
    tick(7, 1, 0, 0,  "R1 unused op code ignored");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int op = int'($urandom % 8);
      int bk = int'($urandom % 4);
      int ap = int'(($urandom % 4) == 0);
      tick(op, bk, ap, -1, "");
      nops(int'($urandom % 12));
    end
    tick(0, 0, 0, -1, "");
    @(negedge clk);
    check_pending();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule